// File: doc/BRIEF.md
# Precise Exception Commit Unit

This unit gives a five-stage in-order pipeline precise exceptions. A fault noticed at fetch (bad instruction address), decode (unknown opcode) or execute (arithmetic overflow) is not acted on where it is seen. It is recorded as a flag bit that moves along with its instruction. At the end of the memory stage the carried flags, a data-address fault reported by the memory stage, and any pending external interrupt lines are judged together. This is the single point where an instruction is either retired or turned into a trap.

When a trap is taken, the unit loads a cause register and an exceptional-PC register holding the address of the trapping instruction. It clears the global interrupt enable, kills every younger instruction, and steers fetch to a fixed handler address in the same cycle. Fetch keeps going sequentially until that moment, so younger instructions may already have used bypassed results; the flush squashes them. A return-from-interrupt pulse sets the enable again. A stall input freezes the whole pipeline, flags included.

Top module: `excCommitUnit`

## Requirements
- R1: A fault flagged at fetch, decode or execute causes no redirect until its instruction reaches the commit cycle. The commit cycle is the third cycle after the one in which the instruction was presented at fetch.
- R2: When one instruction carries several faults, the earliest pipeline stage wins. The order is instruction-address fault, then illegal opcode, then overflow, then data-address fault.
- R3: The cause register reads 0 after reset. On a trap it is loaded with 1 (instruction-address fault), 2 (illegal opcode), 3 (overflow), 4 (data-address fault) or 5 (external interrupt).
- R4: The exceptional-PC register reads 0 after reset. It is loaded only when a trap is taken, with the PC of the committing instruction, and it keeps its value across normal retirement.
- R5: In the commit cycle of a trap, `trapTaken` is 1 and `redirectPc` equals HANDLER_PC. None of the three younger instructions behind it ever asserts `commitValid`.
- R6: An instruction without faults or a taken interrupt asserts `commitValid` in its commit cycle. Back-to-back instructions retire one per cycle.
- R7: If any bit of `irqReq` is high while interrupts are enabled and a valid instruction commits, a trap with cause 5 is taken on that instruction.
- R8: A synchronous fault wins over a simultaneous enabled interrupt, and the cause records the synchronous code.
- R9: `intEnable` is 1 after reset, is 0 in the cycle after any trap, and is 1 again in the cycle after a `rfe` pulse.
- R10: While `intEnable` is 0, interrupt requests cause no trap and the instruction retires normally. Synchronous faults are still taken.
- R11: An interrupt request that arrives while no valid instruction is at the commit point is held off. It is taken on the next valid instruction to commit.
- R12: While `stall` is 1, no trap is taken and nothing retires. Carried flags are held, and a faulting instruction frozen at the commit point traps once the stall is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stall | input | 1 | Freezes every pipeline stage this cycle |
| fetchValid | input | 1 | An instruction is leaving fetch |
| fetchPc | input | PC_W | PC of the instruction leaving fetch |
| fetchPcFault | input | 1 | Instruction-address fault for the fetched instruction |
| decIllegal | input | 1 | Illegal opcode for the instruction in decode |
| exOverflow | input | 1 | Overflow for the instruction in execute |
| memAddrFault | input | 1 | Data-address fault for the instruction in memory |
| irqReq | input | IRQ_N | Level-sensitive external interrupt requests |
| rfe | input | 1 | Return-from-interrupt pulse, sets the enable |
| trapTaken | output | 1 | Trap taken this cycle; kills younger stages |
| redirectPc | output | PC_W | Fetch target, valid when trapTaken is 1 |
| commitValid | output | 1 | Instruction at the commit point retires this cycle |
| causeOut | output | 3 | Cause register |
| epcOut | output | PC_W | Exceptional-PC register |
| intEnable | output | 1 | Global interrupt enable |

## Verification
Single instructions are sent through with each fault alone, with several faults together, and with an interrupt request alongside a fault. These runs separate the priority order from plain OR-ing and from the ordering of interrupts against synchronous faults. Each one is followed by three fault-free younger instructions, so a missing flush shows up as a stray retirement. Masked requests, requests arriving over an empty pipeline, and a faulting instruction held by a stall show whether the enable, the valid gating and the freeze each apply exactly where required.

// File: rtl/excPkg.sv
`timescale 1ns/1ps
package excPkg;
  localparam int NUM_SYNC = 4;
  localparam int NUM_CARRIED = 3;
  localparam int CAUSE_W = 3;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_NONE    = 3'd0,
    CAUSE_PCADDR  = 3'd1,
    CAUSE_ILLEGAL = 3'd2,
    CAUSE_OVF     = 3'd3,
    CAUSE_DATA    = 3'd4,
    CAUSE_IRQ     = 3'd5
  } causeE;

  typedef struct packed {
    logic  holdPipe;
    logic  killYoung;
    logic  loadTrap;
    causeE trapCause;
  } strobeT;
endpackage

// File: rtl/causeEncoder.sv
`timescale 1ns/1ps
module causeEncoder #(
  parameter int N = 4,
  parameter int CW = 3
) (
  input  logic [N-1:0]  syncVec,
  input  logic          irqHit,
  output logic [CW-1:0] code,
  output logic          anyHit
);
  // lowest index = earliest stage = highest priority; irq ranks below all
  always_comb begin
    code = '0;
    anyHit = 1'b0;
    if (irqHit) begin
      code = CW'(N + 1);
      anyHit = 1'b1;
    end
    for (int i = N - 1; i >= 0; i--) begin
      if (syncVec[i]) begin
        code = CW'(i + 1);
        anyHit = 1'b1;
      end
    end
  end
endmodule

// File: rtl/excDatapath.sv
`timescale 1ns/1ps
module excDatapath
  import excPkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobeT                 strobe,
  input  logic                   fetchValid,
  input  logic [PC_W-1:0]        fetchPc,
  input  logic                   fetchPcFault,
  input  logic                   decIllegal,
  input  logic                   exOverflow,
  output logic                   memValid,
  output logic [PC_W-1:0]        memPc,
  output logic [NUM_CARRIED-1:0] memFlags,
  output logic [CAUSE_W-1:0]     causeOut,
  output logic [PC_W-1:0]        epcOut
);
  localparam int STAGES = NUM_CARRIED;   // decode, execute, memory registers

  logic [STAGES-1:0]      stValid;
  logic [PC_W-1:0]        stPc    [STAGES];
  logic [NUM_CARRIED-1:0] stFlags [STAGES];
  logic [NUM_CARRIED-1:0] detectVec;

  // bit s is raised while the instruction moves into stage register s
  assign detectVec = {exOverflow, decIllegal, fetchPcFault};

  for (genvar s = 0; s < STAGES; s++) begin : gStage
    logic                   vIn;
    logic [PC_W-1:0]        pcIn;
    logic [NUM_CARRIED-1:0] fPrev;
    logic                   vQ;
    logic [PC_W-1:0]        pcQ;
    logic [NUM_CARRIED-1:0] fQ;

    if (s == 0) begin : gHead
      assign vIn = fetchValid;
      assign pcIn = fetchPc;
      assign fPrev = '0;
    end else begin : gBody
      assign vIn = stValid[s-1];
      assign pcIn = stPc[s-1];
      assign fPrev = stFlags[s-1];
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        vQ <= 1'b0;
        pcQ <= '0;
        fQ <= '0;
      end else if (strobe.killYoung) begin
        vQ <= 1'b0;
      end else if (!strobe.holdPipe) begin
        vQ <= vIn;
        pcQ <= pcIn;
        fQ <= fPrev | (detectVec & NUM_CARRIED'(1 << s));
      end
    end

    assign stValid[s] = vQ;
    assign stPc[s] = pcQ;
    assign stFlags[s] = fQ;
  end

  assign memValid = stValid[STAGES-1];
  assign memPc = stPc[STAGES-1];
  assign memFlags = stFlags[STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      causeOut <= '0;
      epcOut <= '0;
    end else if (strobe.loadTrap) begin
      causeOut <= strobe.trapCause;
      epcOut <= memPc;
    end
  end

  // R4: exceptional PC changes only on a trap
  assert_epc_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadTrap |=> $stable(epcOut));
  // R3: a loaded cause is never the "none" code
  assert_cause_code_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadTrap |=> (causeOut != '0));
  // R12: stall freezes the commit-stage contents
  assert_stall_freeze_R12: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.holdPipe && !strobe.killYoung) |=> ($stable(memPc) && $stable(memFlags)));
endmodule

// File: rtl/excControl.sv
`timescale 1ns/1ps
module excControl
  import excPkg::*;
#(
  parameter int IRQ_N = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   stall,
  input  logic                   rfe,
  input  logic [IRQ_N-1:0]       irqReq,
  input  logic                   memValid,
  input  logic [NUM_CARRIED-1:0] memFlags,
  input  logic                   memAddrFault,
  output strobeT                 strobe,
  output logic                   trapTaken,
  output logic                   commitValid,
  output logic                   intEnable
);
  logic [NUM_SYNC-1:0] syncVec;
  logic                irqHit;
  logic [CAUSE_W-1:0]  code;
  logic                anyHit;
  logic                intEnQ;

  assign syncVec = memValid ? {memAddrFault, memFlags} : '0;
  assign irqHit = memValid & intEnQ & (|irqReq);

  causeEncoder #(.N(NUM_SYNC), .CW(CAUSE_W)) uEnc (
    .syncVec(syncVec),
    .irqHit(irqHit),
    .code(code),
    .anyHit(anyHit)
  );

  assign trapTaken = !stall && anyHit;
  assign commitValid = !stall && memValid && !anyHit;

  always_comb begin
    strobe.holdPipe = stall;
    strobe.killYoung = trapTaken;
    strobe.loadTrap = trapTaken;
    strobe.trapCause = causeE'(code);
  end

  always_ff @(posedge clk) begin
    if (!rstN) intEnQ <= 1'b1;
    else if (trapTaken) intEnQ <= 1'b0;
    else if (rfe) intEnQ <= 1'b1;
  end
  assign intEnable = intEnQ;

  // R9: any trap masks interrupts next cycle
  assert_mask_after_trap_R9: assert property (@(posedge clk) disable iff (!rstN)
    trapTaken |=> !intEnable);
  // R10: with interrupts masked only a synchronous fault can trap
  assert_masked_sync_only_R10: assert property (@(posedge clk) disable iff (!rstN)
    (trapTaken && !intEnable) |-> (syncVec != '0));
  // R11: a bubble never traps
  assert_no_bubble_trap_R11: assert property (@(posedge clk) disable iff (!rstN)
    trapTaken |-> memValid);
  // R5: the flush empties the commit stage
  assert_flush_R5: assert property (@(posedge clk) disable iff (!rstN)
    trapTaken |=> !memValid);
endmodule

// File: rtl/excCommitUnit.sv
`timescale 1ns/1ps
module excCommitUnit
  import excPkg::*;
#(
  parameter int PC_W = 32,
  parameter int IRQ_N = 4,
  parameter logic [PC_W-1:0] HANDLER_PC = 32'h0000_0180
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               stall,
  input  logic               fetchValid,
  input  logic [PC_W-1:0]    fetchPc,
  input  logic               fetchPcFault,
  input  logic               decIllegal,
  input  logic               exOverflow,
  input  logic               memAddrFault,
  input  logic [IRQ_N-1:0]   irqReq,
  input  logic               rfe,
  output logic               trapTaken,
  output logic [PC_W-1:0]    redirectPc,
  output logic               commitValid,
  output logic [2:0]         causeOut,
  output logic [PC_W-1:0]    epcOut,
  output logic               intEnable
);
  strobeT                 strobe;
  logic                   memValid;
  logic [PC_W-1:0]        memPc;
  logic [NUM_CARRIED-1:0] memFlags;

  excControl #(.IRQ_N(IRQ_N)) uCtrl (
    .clk(clk), .rstN(rstN), .stall(stall), .rfe(rfe), .irqReq(irqReq),
    .memValid(memValid), .memFlags(memFlags), .memAddrFault(memAddrFault),
    .strobe(strobe), .trapTaken(trapTaken), .commitValid(commitValid),
    .intEnable(intEnable)
  );

  excDatapath #(.PC_W(PC_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .fetchValid(fetchValid), .fetchPc(fetchPc), .fetchPcFault(fetchPcFault),
    .decIllegal(decIllegal), .exOverflow(exOverflow),
    .memValid(memValid), .memPc(memPc), .memFlags(memFlags),
    .causeOut(causeOut), .epcOut(epcOut)
  );

  assign redirectPc = HANDLER_PC;
endmodule

// File: tb/tb_excCommitUnit.sv
`timescale 1ns/1ps
module tb_excCommitUnit;
  localparam logic [31:0] HANDLER = 32'h0000_0180;

  logic clk = 1'b0;
  logic rstN, stall, fetchValid, fetchPcFault, decIllegal, exOverflow, memAddrFault, rfe;
  logic [31:0] fetchPc;
  logic [3:0] irqReq;
  logic trapTaken, commitValid, intEnable;
  logic [31:0] redirectPc, epcOut;
  logic [2:0] causeOut;

  int checks = 0;
  int errors = 0;
  logic [2:0] lastCause = 3'd0;
  logic [31:0] lastEpc = 32'd0;

  always #2.5 clk = ~clk;

  excCommitUnit #(.PC_W(32), .IRQ_N(4), .HANDLER_PC(HANDLER)) dut (
    .clk(clk), .rstN(rstN), .stall(stall), .fetchValid(fetchValid), .fetchPc(fetchPc),
    .fetchPcFault(fetchPcFault), .decIllegal(decIllegal), .exOverflow(exOverflow),
    .memAddrFault(memAddrFault), .irqReq(irqReq), .rfe(rfe), .trapTaken(trapTaken),
    .redirectPc(redirectPc), .commitValid(commitValid), .causeOut(causeOut),
    .epcOut(epcOut), .intEnable(intEnable)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idleInputs();
    stall = 0; fetchValid = 0; fetchPc = '0; fetchPcFault = 0; decIllegal = 0;
    exOverflow = 0; memAddrFault = 0; irqReq = '0; rfe = 0;
  endtask

  task automatic doRfe();
    @(negedge clk); idleInputs(); rfe = 1;
    @(negedge clk); rfe = 0; #1;
    chk(intEnable == 1'b1, "R9", "enable after rfe", 32'(intEnable), 32'd1);
  endtask

  // one instruction followed by three clean ones; faults injected at their stages
  task automatic runScenario(input string name, input logic pf, input logic ill,
                             input logic ovf, input logic maf, input logic irq,
                             input bit expTake, input logic [2:0] expCause,
                             input logic [31:0] base);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      idleInputs();
      fetchValid = 1; fetchPc = base + 32'(4 * k);
      fetchPcFault = (k == 0) && pf;
      decIllegal = (k == 1) && ill;
      exOverflow = (k == 2) && ovf;
      memAddrFault = (k == 3) && maf;
      irqReq = ((k == 3) && irq) ? 4'b0100 : 4'b0000;
      #1;
      if (k < 3) begin
        chk(trapTaken == 1'b0, "R1", {name, " early trap"}, 32'(trapTaken), 32'd0);
      end else begin
        chk(trapTaken == expTake, "R5", {name, " trap at commit"}, 32'(trapTaken), 32'(expTake));
        if (expTake)
          chk(redirectPc == HANDLER, "R5", {name, " redirect"}, redirectPc, HANDLER);
        chk(commitValid == !expTake, "R6", {name, " retire"}, 32'(commitValid), 32'(!expTake));
      end
    end
    if (expTake) begin lastCause = expCause; lastEpc = base; end
    for (int k = 4; k < 7; k++) begin
      @(negedge clk);
      idleInputs();
      #1;
      chk(commitValid == !expTake, "R5", {name, " younger retire"}, 32'(commitValid), 32'(!expTake));
      chk(trapTaken == 1'b0, "R5", {name, " no second trap"}, 32'(trapTaken), 32'd0);
      if (k == 4) begin
        chk(causeOut == lastCause, "R2", {name, " cause"}, 32'(causeOut), 32'(lastCause));
        chk(epcOut == lastEpc, "R4", {name, " epc"}, epcOut, lastEpc);
        if (expTake)
          chk(intEnable == 1'b0, "R9", {name, " enable cleared"}, 32'(intEnable), 32'd0);
      end
    end
    @(negedge clk);
  endtask

  task automatic bubbleIrq(input logic [31:0] base);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      idleInputs();
      irqReq = (k < 7) ? 4'b0001 : 4'b0000;
      if (k == 3) begin fetchValid = 1; fetchPc = base; end
      #1;
      if (k < 6)
        chk(trapTaken == 1'b0, "R11", "irq over bubble", 32'(trapTaken), 32'd0);
      else if (k == 6)
        chk(trapTaken == 1'b1, "R11", "irq on next valid", 32'(trapTaken), 32'd1);
      else begin
        chk(causeOut == 3'd5, "R7", "irq cause", 32'(causeOut), 32'd5);
        chk(epcOut == base, "R11", "irq epc", epcOut, base);
      end
    end
    lastCause = 3'd5; lastEpc = base;
  endtask

  task automatic stallHold(input logic [31:0] base);
    for (int k = 0; k < 7; k++) begin
      @(negedge clk);
      idleInputs();
      if (k == 0) begin fetchValid = 1; fetchPc = base; end
      if (k == 2) exOverflow = 1;
      if (k == 3 || k == 4) stall = 1;
      #1;
      if (k == 3 || k == 4) begin
        chk(trapTaken == 1'b0, "R12", "trap during stall", 32'(trapTaken), 32'd0);
        chk(commitValid == 1'b0, "R12", "retire during stall", 32'(commitValid), 32'd0);
      end
      if (k == 5)
        chk(trapTaken == 1'b1, "R12", "trap after stall", 32'(trapTaken), 32'd1);
      if (k == 6) begin
        chk(causeOut == 3'd3, "R12", "held flag cause", 32'(causeOut), 32'd3);
        chk(epcOut == base, "R12", "held epc", epcOut, base);
      end
    end
    lastCause = 3'd3; lastEpc = base;
  endtask

  initial begin
    #500000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idleInputs();
    rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    chk(causeOut == 3'd0, "R3", "reset cause", 32'(causeOut), 32'd0);
    chk(epcOut == 32'd0, "R4", "reset epc", epcOut, 32'd0);
    chk(intEnable == 1'b1, "R9", "reset enable", 32'(intEnable), 32'd1);
    chk(trapTaken == 1'b0 && commitValid == 1'b0, "R6", "reset idle",
        32'({trapTaken, commitValid}), 32'd0);

    runScenario("clean", 0, 0, 0, 0, 0, 0, 3'd0, 32'h100);
    runScenario("pcaddr", 1, 0, 0, 0, 0, 1, 3'd1, 32'h200);
    doRfe();
    runScenario("illegal", 0, 1, 0, 0, 0, 1, 3'd2, 32'h300);
    doRfe();
    runScenario("overflow", 0, 0, 1, 0, 0, 1, 3'd3, 32'h400);
    doRfe();
    runScenario("dataaddr", 0, 0, 0, 1, 0, 1, 3'd4, 32'h500);
    doRfe();
    runScenario("all four R2", 1, 1, 1, 1, 0, 1, 3'd1, 32'h600);
    doRfe();
    runScenario("ill+ovf+mem R2", 0, 1, 1, 1, 0, 1, 3'd2, 32'h640);
    doRfe();
    runScenario("ovf+mem R2", 0, 0, 1, 1, 0, 1, 3'd3, 32'h680);
    doRfe();
    runScenario("irq R7", 0, 0, 0, 0, 1, 1, 3'd5, 32'h700);
    runScenario("masked irq R10", 0, 0, 0, 0, 1, 0, 3'd0, 32'h740);
    runScenario("masked sync R10", 0, 0, 1, 0, 1, 1, 3'd3, 32'h780);
    doRfe();
    runScenario("irq+ill R8", 0, 1, 0, 0, 1, 1, 3'd2, 32'h7c0);
    doRfe();
    bubbleIrq(32'h800);
    doRfe();
    stallHold(32'h900);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule